// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector and Busy Tracker

This block watches the clock and data lines of an open-drain two-wire serial bus, after a small synchronizer, and reports the framing conditions that bound a transfer. A falling data edge while the clock stays high marks the opening of a transfer. A rising data edge while the clock stays high marks its end. Each condition is reported as a one-cycle pulse on its own output.

The block also keeps the bus state that a local master needs before it may open a transfer of its own. `busy` is set from the opening condition until the closing one. An opening condition seen while `busy` is already set is a restart and is reported on a separate pulse. `bus_free` is not raised at the closing edge. It rises only after a programmable number of system clocks of quiet, and a new opening condition during that wait cancels it.

Top module: `twb_cond_monitor`

## Requirements
- R1: An opening condition is a sampled data level going 1 to 0 while the sampled clock level is 1 both before and after. When `busy` is 0, it produces a one-cycle `start_pulse`. The pulse is high in the cycle after the SYNC_STAGES-th rising edge that follows the first edge capturing the new data level.
- R2: A closing condition is a sampled data level going 0 to 1 while the sampled clock level is 1 both before and after. It produces a one-cycle `stop_pulse` with the same latency as R1.
- R3: An opening condition seen while `busy` is 1 produces `rstart_pulse` and no `start_pulse`.
- R4: `busy` is 1 from the cycle in which `start_pulse` or `rstart_pulse` is high until the cycle in which `stop_pulse` is high. In that cycle `busy` reads 0.
- R5: `bus_free` drops in the cycle in which `start_pulse` is high. After `stop_pulse`, `bus_free` rises exactly max(`idle_cycles`,1) cycles later. `idle_cycles` is held steady during the wait. `bus_free` and `busy` are never both 1.
- R6: An opening condition during the idle wait cancels the wait. `bus_free` stays 0 and `busy` returns to 1.
- R7: A data edge sampled in the same cycle as a clock edge is not a condition. No pulse follows it, and `busy` and `bus_free` do not change.
- R8: A closing condition is detected at any point of a transfer, including partway through a byte, and ends the transfer.
- R9: After reset, all three pulses are 0, `busy` is 0 and `bus_free` is 1.
- R10: At most one of the three pulses is high in any cycle, and no pulse stays high for two consecutive cycles.
- R11: A closing condition seen while `bus_free` is already 1 still pulses `stop_pulse`, and `bus_free` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line level |
| sda_i | input | 1 | Raw bus data line level |
| idle_cycles | input | IDLE_W | System clocks of quiet required after a closing condition |
| start_pulse | output | 1 | One-cycle pulse for an opening condition on an idle bus |
| rstart_pulse | output | 1 | One-cycle pulse for an opening condition while busy |
| stop_pulse | output | 1 | One-cycle pulse for a closing condition |
| busy | output | 1 | A transfer is in progress |
| bus_free | output | 1 | Idle time after the last closing condition has elapsed |

## Verification
The embedded assertions check the cycle-level invariants on every cycle. These are the exclusivity and single-cycle length of the pulses, `busy` agreeing with each pulse, restart only following a busy bus, and `bus_free` never coexisting with `busy` or rising on a closing edge. Only the bench scenarios can show the exact idle wait, the cancellation of the wait by a quick new opening, and the rejection of data edges that coincide with clock edges. They also show mid-byte closing and a stray closing on a free bus. The bench checks these against a behavioural history model, cycle by cycle, and with directed counts.

// File: rtl/twb_cond_pkg.sv
package twb_cond_pkg;
  // Bus condition events decoded in one sampled cycle.
  typedef struct packed {
    logic open_c;   // data fell with clock steady high
    logic close_c;  // data rose with clock steady high
  } line_event_t;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage [STAGES];

  // Lines rest high, so reset every stage to 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[LAST];
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
  import twb_cond_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_s,
  input  logic        sda_s,
  output line_event_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Clock must be high in both samples, so a data edge that lands
  // with a clock edge is never a condition (R7).
  logic clk_steady_hi;
  assign clk_steady_hi = scl_q & scl_s;

  always_comb begin
    ev.open_c  = clk_steady_hi &  sda_q & ~sda_s;  // R1
    ev.close_c = clk_steady_hi & ~sda_q &  sda_s;  // R2, R8
  end
endmodule

// File: rtl/twb_busy_tracker.sv
module twb_busy_tracker
  import twb_cond_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  line_event_t      ev,
  input  logic [CNT_W-1:0] idle_cycles,
  output logic             start_pulse,
  output logic             rstart_pulse,
  output logic             stop_pulse,
  output logic             busy,
  output logic             bus_free
);
  localparam int EXT_W = CNT_W + 1;

  logic             waiting;
  logic [CNT_W-1:0] wait_cnt;
  logic [EXT_W-1:0] wait_next;
  logic             wait_done;

  assign wait_next = {1'b0, wait_cnt} + EXT_W'(1);
  // A programmed zero behaves as one cycle.
  assign wait_done = (wait_next >= {1'b0, idle_cycles});

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pulse  <= 1'b0;
      rstart_pulse <= 1'b0;
      stop_pulse   <= 1'b0;
      busy         <= 1'b0;
      bus_free     <= 1'b1;
      waiting      <= 1'b0;
      wait_cnt     <= '0;
    end else begin
      start_pulse  <= ev.open_c & ~busy;
      rstart_pulse <= ev.open_c &  busy;
      stop_pulse   <= ev.close_c;
      if (ev.open_c) begin
        busy     <= 1'b1;
        bus_free <= 1'b0;
        waiting  <= 1'b0;          // R6: cancel pending idle wait
      end else if (ev.close_c) begin
        busy     <= 1'b0;
        wait_cnt <= '0;
        waiting  <= ~bus_free;     // R11: already free stays free
      end else if (waiting) begin
        if (wait_done) begin
          bus_free <= 1'b1;
          waiting  <= 1'b0;
        end else begin
          wait_cnt <= wait_next[CNT_W-1:0];
        end
      end
    end
  end

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_pulse, rstart_pulse, stop_pulse}));

  p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  p_stop_single_r10: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);

  p_open_sets_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (start_pulse || rstart_pulse) |-> busy);

  p_close_clears_busy_r4: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !busy);

  p_restart_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    rstart_pulse |-> $past(busy));

  p_free_excl_busy_r5: assert property (@(posedge clk) disable iff (rst)
    bus_free |-> !busy);

  p_free_not_at_stop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_free) |-> !stop_pulse);

  p_start_drops_free_r5: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> !bus_free);
endmodule

// File: rtl/twb_cond_monitor.sv
module twb_cond_monitor
  import twb_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [IDLE_W-1:0] idle_cycles,
  output logic              start_pulse,
  output logic              rstart_pulse,
  output logic              stop_pulse,
  output logic              busy,
  output logic              bus_free
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  line_event_t      ev;

  twb_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (lines_s)
  );

  twb_cond_detect u_detect (
    .clk   (clk),
    .rst   (rst),
    .scl_s (lines_s[1]),
    .sda_s (lines_s[0]),
    .ev    (ev)
  );

  twb_busy_tracker #(.CNT_W(IDLE_W)) u_track (
    .clk          (clk),
    .rst          (rst),
    .ev           (ev),
    .idle_cycles  (idle_cycles),
    .start_pulse  (start_pulse),
    .rstart_pulse (rstart_pulse),
    .stop_pulse   (stop_pulse),
    .busy         (busy),
    .bus_free     (bus_free)
  );
endmodule

// File: tb/twb_cond_monitor_tb.sv
module twb_cond_monitor_tb;
  localparam int SYNC   = 2;
  localparam int IDLE_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [IDLE_W-1:0] idle = 16'd5;
  logic start_pulse, rstart_pulse, stop_pulse, busy, bus_free;

  always #5 clk = ~clk;

  twb_cond_monitor #(.SYNC_STAGES(SYNC), .IDLE_W(IDLE_W)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_drv),
    .idle_cycles(idle), .start_pulse(start_pulse),
    .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
    .busy(busy), .bus_free(bus_free)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: history of raw samples, conditions from
  // the delayed pair, plus bus state and an idle countdown.
  bit h_scl[$], h_sda[$];
  bit m_start, m_rstart, m_stop, m_busy, m_free;
  int m_wait;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      h_scl = {}; h_sda = {};
      for (int i = 0; i < SYNC + 2; i++) begin h_scl.push_back(1); h_sda.push_back(1); end
      m_start = 0; m_rstart = 0; m_stop = 0; m_busy = 0; m_free = 1; m_wait = -1;
    end else begin
      int L, lim;
      bit ns, os, nd, od, cs, cp;
      h_scl.push_back(scl_drv); h_sda.push_back(sda_drv);
      L  = h_scl.size() - 1;
      ns = h_scl[L-SYNC]; os = h_scl[L-SYNC-1];
      nd = h_sda[L-SYNC]; od = h_sda[L-SYNC-1];
      cs = ns && os && od && !nd;
      cp = ns && os && !od && nd;
      m_start = cs && !m_busy; m_rstart = cs && m_busy; m_stop = cp;
      lim = (idle == 0) ? 1 : int'(idle);
      if (cs) begin m_busy = 1; m_free = 0; m_wait = -1; end
      else if (cp) begin m_busy = 0; if (!m_free) m_wait = 0; end
      else if (m_wait >= 0) begin
        m_wait++;
        if (m_wait >= lim) begin m_free = 1; m_wait = -1; end
      end
      while (h_scl.size() > 16) begin void'(h_scl.pop_front()); void'(h_sda.pop_front()); end
    end
  end

  // Per-cycle comparison plus observation counters.
  int n_start = 0, n_rstart = 0, n_stop = 0, n_free_rise = 0, n_free_fall = 0;
  int t_stop = 0, t_free = 0;
  bit prev_free = 1;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 start_pulse", start_pulse, m_start);
      check("R3 rstart_pulse", rstart_pulse, m_rstart);
      check("R2 stop_pulse", stop_pulse, m_stop);
      check("R4 busy", busy, m_busy);
      check("R5 bus_free", bus_free, m_free);
      if (start_pulse) n_start++;
      if (rstart_pulse) n_rstart++;
      if (stop_pulse) begin n_stop++; t_stop = cyc; end
      if (bus_free && !prev_free) begin n_free_rise++; t_free = cyc; end
      if (!bus_free && prev_free) n_free_fall++;
    end
    prev_free = bus_free;
  end

  always @(posedge clk) begin
    if (cyc == 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drive(input bit c, input bit d, input int n);
    @(posedge clk); #2;
    scl_drv = c; sda_drv = d;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic send_bit(input bit b);
    drive(0, b, 4); drive(1, b, 4);
  endtask

  task automatic open_bus();   // from idle high lines
    drive(1, 1, 4); drive(1, 0, 4); drive(0, 0, 4);
  endtask

  task automatic close_bus();
    drive(0, 0, 4); drive(1, 0, 4); drive(1, 1, 4);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  int s0, r0, p0, fr0, ff0;
  task automatic snap();
    s0 = n_start; r0 = n_rstart; p0 = n_stop; fr0 = n_free_rise; ff0 = n_free_fall;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R9 reset state
    check("R9 start_pulse", start_pulse, 0);
    check("R9 stop_pulse", stop_pulse, 0);
    check("R9 busy", busy, 0);
    check("R9 bus_free", bus_free, 1);

    // Plain transfer, byte 0xA5 plus ack, then close; idle wait of 5
    snap();
    open_bus();
    for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
    send_bit(0);
    close_bus();
    settle(12);
    check("R1 start count", n_start - s0, 1);
    check("R2 stop count", n_stop - p0, 1);
    check("R5 idle wait", t_free - t_stop, 5);
    check("R5 free after wait", bus_free, 1);

    // Restart inside a transfer
    snap();
    open_bus();
    send_bit(1); send_bit(0);
    drive(0, 1, 4); drive(1, 1, 4); drive(1, 0, 4); drive(0, 0, 4);
    send_bit(1);
    close_bus();
    settle(12);
    check("R3 restart count", n_rstart - r0, 1);
    check("R3 start count", n_start - s0, 1);
    check("R4 busy after close", busy, 0);

    // Close partway through a byte
    snap();
    open_bus();
    send_bit(1); send_bit(1); send_bit(0);
    drive(0, 0, 3); drive(1, 0, 3); drive(1, 1, 3);
    settle(3);
    check("R8 stop mid-byte", n_stop - p0, 1);
    check("R8 busy cleared", busy, 0);
    settle(10);

    // Quick reopen during idle wait cancels it
    snap();
    open_bus();
    send_bit(0);
    drive(0, 0, 4); drive(1, 0, 4); drive(1, 1, 2); drive(1, 0, 4); drive(0, 0, 4);
    settle(2);
    check("R6 no free rise", n_free_rise - fr0, 0);
    check("R6 busy again", busy, 1);
    check("R6 start count", n_start - s0, 2);
    close_bus();
    settle(12);

    // Data edges coinciding with clock edges
    snap();
    drive(0, 1, 4); drive(1, 0, 4); drive(0, 1, 4); drive(1, 1, 4);
    settle(6);
    check("R7 no start", n_start - s0, 0);
    check("R7 no stop", n_stop - p0, 0);
    check("R7 busy", busy, 0);
    check("R7 free", bus_free, 1);

    // Stray close on a free bus
    snap();
    drive(0, 1, 4); drive(0, 0, 4); drive(1, 0, 4); drive(1, 1, 4);
    settle(10);
    check("R11 stop seen", n_stop - p0, 1);
    check("R11 free never fell", n_free_fall - ff0, 0);

    // Programmed zero acts as one cycle
    idle = 16'd0;
    open_bus(); send_bit(1); close_bus();
    settle(8);
    check("R5 zero wait", t_free - t_stop, 1);

    // Long wait
    idle = 16'd20;
    open_bus(); send_bit(0); close_bus();
    settle(30);
    check("R5 long wait", t_free - t_stop, 20);
    check("R10 pulses seen", (n_start > 0 && n_stop > 0) ? 1 : 0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule